// File: doc/BRIEF.md
# Second-Order Sinc Decimation Filter

This block turns the one-bit stream from a first-order delta-sigma modulator into 16-bit words at the output rate. The stream arrives at the oversampled clock rate. Each incoming bit is first mapped to a signed value. Two cascaded accumulators running at the oversampled rate sum these values. A free-running divider produces the output-rate clock. On each rising edge of that clock, two differencing stages turn the accumulated value into one filtered, decimated sample.

With the default decimation of 256 (for example 5.12 MHz in and 20 kHz out), every datapath register is order × log2(decimation) = 16 bits wide. All arithmetic wraps at 16 bits, and the differencing stages cancel the wrap of the accumulators. The output-rate clock rises on a falling edge of the oversampled clock. The differencing stages therefore capture accumulator values half a cycle after those values settled. A valid pulse marks each new sample once the differencing history holds real data.

Reset is asynchronous and active low. It is released into the filter through a two-stage synchronizer.

Top module: `sinc2_decimator`

## Requirements
- R1: With the default setting, an input bit of 1 enters the first accumulator as +1 and a bit of 0 enters it as −1. With the option parameter cleared, a 0 enters as 0.
- R2: `rate_clk` has a period of exactly 256 oversampled clock cycles and a 50% duty cycle. Each of its rising edges falls on a falling edge of `clk`.
- R3: Reset release takes effect at the second rising `clk` edge after `rst_n` rises, and input bits are taken from the third. The first `rate_clk` rising edge follows the 255th bit taken after release.
- R4: At each `rate_clk` rising edge, `sample_out` loads the second-order sinc result, computed bit-accurately with 16-bit wrap-around arithmetic. Between those edges it holds its value.
- R5: `sample_vld` is high for exactly one `clk` cycle after each `rate_clk` rising edge, starting with the second edge after reset. It stays low after the first edge.
- R6: With a constant all-ones input, the settled output equals 256² mod 2^16 = 0x0000.
- R7: With an alternating 1/0 input, the settled output equals the mid-scale value 0x0000.
- R8: While `rst_n` is low, `sample_out`, `sample_vld` and `rate_clk` are all 0, even when reset is asserted in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampled clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_bit | input | 1 | Modulator output bit |
| sample_out | output | 16 | Decimated filtered sample (two's complement) |
| rate_clk | output | 1 | Output-rate clock, rising on a falling `clk` edge |
| sample_vld | output | 1 | One-cycle pulse marking a new valid sample |

## Verification
The bench drives long runs of constant ones and alternating bits, so that the accumulators wrap many times. A filter that saturated, or that had lost the wrap cancellation, would settle away from zero in those runs. It then drives bursts of random density. Each output is compared with a reference that counts edges from reset release. An off-by-one divider or a misplaced reset release would move every sample by a bit or more. The bench also looks at the first output-rate edge, where a premature valid pulse would expose a sample built on empty history. Finally it asserts reset in the middle of a run to show that every output and all history clear at once.

// File: rtl/sinc2_pkg.sv
package sinc2_pkg;
  localparam int SINC_ORDER = 2;

  function automatic int sinc_width(input int order, input int log2_decim);
    return order * log2_decim;
  endfunction
endpackage

// File: rtl/sinc2_rst_sync.sv
module sinc2_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/sinc2_integrators.sv
module sinc2_integrators #(
  parameter int ORDER = 2,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] step_in,
  output logic [W-1:0] acc_out
);
  logic [W-1:0] acc_q [ORDER];
  logic [W-1:0] acc_d [ORDER];

  // Each stage adds the previous stage's registered value (wraps modulo 2^W).
  always_comb begin
    acc_d[0] = acc_q[0] + step_in;
    for (int s = 1; s < ORDER; s++) acc_d[s] = acc_q[s] + acc_q[s-1];
  end

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q[g] <= '0;
      else        acc_q[g] <= acc_d[g];
    end
  end

  assign acc_out = acc_q[ORDER-1];
endmodule

// File: rtl/sinc2_rate_gen.sv
module sinc2_rate_gen #(
  parameter int LOG2 = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick,
  output logic primed,
  output logic rate_clk
);
  localparam int HALF = 2 ** (LOG2 - 1);

  logic [LOG2-1:0] cnt_q, cnt_d;
  logic            seen_q, seen_d;
  logic            rate_q, rate_d;

  always_comb begin
    cnt_d  = cnt_q + 1'b1;
    tick   = &cnt_q;
    seen_d = seen_q | tick;
    rate_d = tick | (seen_q & (cnt_q < LOG2'(HALF - 1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Output-rate flops run on the falling edge of the oversampled clock.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      rate_q <= 1'b0;
    end else begin
      seen_q <= seen_d;
      rate_q <= rate_d;
    end
  end

  assign primed   = seen_q;
  assign rate_clk = rate_q;
endmodule

// File: rtl/sinc2_combs.sv
module sinc2_combs #(
  parameter int ORDER = 2,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         primed,
  input  logic [W-1:0] acc_in,
  output logic [W-1:0] sample,
  output logic         vld
);
  logic [W-1:0] dly_q [ORDER];
  logic [W-1:0] dly_d [ORDER];
  logic [W-1:0] tap   [ORDER];
  logic [W-1:0] chain;
  logic [W-1:0] smp_q, smp_d;
  logic         vld_q, vld_d;

  // Differencing stages chained without registers between them.
  always_comb begin
    chain = acc_in;
    for (int s = 0; s < ORDER; s++) begin
      tap[s] = chain;
      chain  = chain - dly_q[s];
    end
    for (int s = 0; s < ORDER; s++) dly_d[s] = tick ? tap[s] : dly_q[s];
    smp_d = tick ? chain : smp_q;
    vld_d = tick & primed;
  end

  for (genvar g = 0; g < ORDER; g++) begin : g_dly
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) dly_q[g] <= '0;
      else        dly_q[g] <= dly_d[g];
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
      vld_q <= 1'b0;
    end else begin
      smp_q <= smp_d;
      vld_q <= vld_d;
    end
  end

  assign sample = smp_q;
  assign vld    = vld_q;
endmodule

// File: rtl/sinc2_decimator.sv
module sinc2_decimator
  import sinc2_pkg::*;
#(
  parameter int DECIM_LOG2  = 8,
  parameter bit ZERO_IS_NEG = 1'b1
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     mod_bit,
  output logic [sinc_width(SINC_ORDER, DECIM_LOG2)-1:0] sample_out,
  output logic                                     rate_clk,
  output logic                                     sample_vld
);
  localparam int W = sinc_width(SINC_ORDER, DECIM_LOG2);

  logic         rst_i_n;
  logic [W-1:0] step;
  logic [W-1:0] acc;
  logic         tick;
  logic         primed;

  // R1: bit 1 -> +1, bit 0 -> -1 (or 0 when ZERO_IS_NEG is cleared).
  always_comb begin
    if (mod_bit)          step = W'(1);
    else if (ZERO_IS_NEG) step = '1;
    else                  step = '0;
  end

  sinc2_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  sinc2_integrators #(.ORDER(SINC_ORDER), .W(W)) u_int (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .step_in (step),
    .acc_out (acc)
  );

  sinc2_rate_gen #(.LOG2(DECIM_LOG2)) u_rate (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .tick     (tick),
    .primed   (primed),
    .rate_clk (rate_clk)
  );

  sinc2_combs #(.ORDER(SINC_ORDER), .W(W)) u_comb (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .tick   (tick),
    .primed (primed),
    .acc_in (acc),
    .sample (sample_out),
    .vld    (sample_vld)
  );
endmodule

// File: rtl/sinc2_checker.sv
module sinc2_checker #(
  parameter int LOG2 = 8,
  parameter int W    = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] sample_out,
  input logic         rate_clk,
  input logic         sample_vld
);
  localparam int PERIOD = 2 ** LOG2;
  localparam int GW     = LOG2 + 2;

  logic          prev_q;
  logic [GW-1:0] gap_q;
  logic [1:0]    rises_q;
  logic          rose_w;

  assign rose_w = rate_clk & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      gap_q   <= '0;
      rises_q <= '0;
    end else begin
      prev_q <= rate_clk;
      if (rose_w)        gap_q <= GW'(1);
      else if (~&gap_q)  gap_q <= gap_q + 1'b1;
      if (rose_w && rises_q != 2'd3) rises_q <= rises_q + 1'b1;
    end
  end

  assert_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rose_w && rises_q != 2'd0) |-> (gap_q == GW'(PERIOD)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sample_out) |-> $rose(rate_clk));

  assert_vld_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |-> $rose(rate_clk));

  assert_first_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |-> (rises_q != 2'd0));

  assert_reset_clear_R8: assert property (@(posedge clk)
    !rst_n |-> (sample_out == '0 && !sample_vld && !rate_clk));
endmodule

bind sinc2_decimator sinc2_checker #(.LOG2(DECIM_LOG2), .W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sample_out (sample_out),
  .rate_clk   (rate_clk),
  .sample_vld (sample_vld)
);

// File: tb/sim_sinc2_decimator.sv
module sim_sinc2_decimator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mod_bit = 1'b0;
  logic [15:0] sample_out;
  logic        rate_clk;
  logic        sample_vld;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  sinc2_decimator u0 (
    .clk(clk), .rst_n(rst_n), .mod_bit(mod_bit),
    .sample_out(sample_out), .rate_clk(rate_clk), .sample_vld(sample_vld)
  );

  always #2 clk = ~clk;

  // Reference model state
  logic [15:0] m_i1, m_i2, m_z1, m_z2, m_out;
  logic [7:0]  m_cnt;
  bit          m_seen, m_vld, m_rate;
  int          m_rel;
  int          edges_seen, bits_taken, first_edge_bits;

  function automatic logic [15:0] map_bit(input bit b);
    return b ? 16'h0001 : 16'hFFFF;  // R1 default mapping
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_i1 = '0; m_i2 = '0; m_z1 = '0; m_z2 = '0; m_out = '0;
    m_cnt = '0; m_seen = 0; m_vld = 0; m_rate = 0; m_rel = 0;
    edges_seen = 0; bits_taken = 0; first_edge_bits = -1;
  endtask

  task automatic step(input bit b);
    logic [15:0] c1, c2;
    bit tk, nr;
    mod_bit = b;
    @(posedge clk);
    if (rst_n && m_rel >= 2) begin
      m_i2 = m_i2 + m_i1;
      m_i1 = m_i1 + map_bit(b);
      m_cnt = m_cnt + 8'd1;
      bits_taken++;
    end else if (rst_n) m_rel++;
    @(negedge clk);
    #1;
    if (rst_n && m_rel >= 2) begin
      tk = (m_cnt == 8'd255);
      nr = tk || (m_seen && m_cnt < 8'd127);
      if (tk) begin
        c1 = m_i2 - m_z1;
        c2 = c1 - m_z2;
        m_z1 = m_i2; m_z2 = c1; m_out = c2;
        m_vld = m_seen; m_seen = 1;
        edges_seen++;
        if (first_edge_bits < 0) first_edge_bits = bits_taken;
      end else m_vld = 0;
      m_rate = nr;
    end
    check("R4 sample (R1 mapping)", sample_out, m_out);
    check("R5 valid", {15'd0, sample_vld}, {15'd0, m_vld});
    check("R2 rate_clk", {15'd0, rate_clk}, {15'd0, m_rate});
  endtask

  task automatic apply_reset(input int cycles);
    rst_n = 1'b0;
    model_reset();
    #0.5;
    check("R8 reset sample", sample_out, 16'h0000);
    check("R8 reset valid", {15'd0, sample_vld}, 16'h0000);
    check("R8 reset rate", {15'd0, rate_clk}, 16'h0000);
    for (int i = 0; i < cycles; i++) step(1'b0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    #1;
    apply_reset(4);

    // R6: constant ones, six output periods
    for (int i = 0; i < 6 * 256; i++) step(1'b1);
    check("R3 first edge after 255 bits", 16'(first_edge_bits), 16'd255);
    check("R6 all-ones settled", sample_out, 16'h0000);

    // R7: alternating pattern
    for (int i = 0; i < 6 * 256; i++) step(i[0]);
    check("R7 alternating settled", sample_out, 16'h0000);

    // Random density bursts (wrap-around, R4)
    for (int p = 0; p < 16; p++) begin
      int dens = $urandom_range(0, 255);
      for (int i = 0; i < 256; i++) step(($urandom % 256) < dens);
    end

    // R8: reset in the middle of a period, then R5 first-edge behaviour again
    for (int i = 0; i < 100; i++) step($urandom % 2 == 1);
    apply_reset(3);
    for (int i = 0; i < 258; i++) step(1'b1);
    check("R5 no valid after first edge", 16'(edges_seen), 16'd1);
    for (int i = 0; i < 4 * 256; i++) step(($urandom % 4) != 0);
    check("R3 first edge after reset", 16'(first_edge_bits), 16'd255);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule